// File: doc/BRIEF.md
# Transfer Descriptor Schedule Walker

This block steps through a memory of transfer descriptors on behalf of a host controller's packet engine. The memory is split into three schedule classes: isochronous, interrupt and asynchronous. Each class holds 32 descriptor slots, and each slot has one control word. A frame-start strobe begins a pass. The pass visits the enabled classes in a fixed order. Within a class the walker reads one slot at a time through a synchronous memory port and decides whether that slot becomes a transaction.

A slot that is to be issued is presented to the packet engine as a held request. The walker waits for the engine to report completion before it reads anything else. The next slot to visit is chosen from the slot's own control word, which combines three things:

- a skip flag;
- a forward-only jump pointer;
- a marker that ends the class.

The pass ends when the last enabled class has finished. The walker then waits idle for the next frame-start strobe.

Top module: `sched_walker`

## Requirements
- R1: While reset is held and afterwards until a frame start, `busy`, `mem_rd_en` and `txn_req` are low.
- R2: A frame start while idle begins a pass over the enabled classes in the order isochronous (class code 0, `sched_en[0]`), interrupt (code 1, `sched_en[1]`), asynchronous (code 2, `sched_en[2]`). Disabled classes are passed by. With no class enabled the strobe starts nothing.
- R3: The control word has these fields: jump pointer in bits 4..0, active in bit 5, done in bit 6, skip in bit 7, last in bit 8. A non-skipped slot is issued as a transaction only when active is 1 and done is 0.
- R4: After a non-skipped slot, a jump pointer greater than the current slot index makes the walker visit that slot next.
- R5: A jump pointer equal to or below the current index, including zero, makes the walker visit the following slot instead.
- R6: A slot with skip set is never issued. Its jump pointer and its last flag are ignored, and the following slot is visited next.
- R7: A non-skipped slot with last set ends its class after that slot has been handled.
- R8: A class with no effective last flag ends after slot 31.
- R9: `txn_req` stays high with a stable `txn_class` and `txn_slot` until `txn_done` is seen. No memory read happens while it is high.
- R10: A frame start that arrives during a pass is ignored.
- R11: Every visited slot is read exactly once, at address {class code, slot index}. Within a pass the read addresses strictly increase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe starting a pass |
| sched_en | input | 3 | Class enables: bit 0 isochronous, 1 interrupt, 2 asynchronous |
| mem_rd_en | output | 1 | Descriptor memory read strobe |
| mem_rd_addr | output | 7 | Read address {class, slot} |
| mem_rd_data | input | 9 | Control word, valid the cycle after the read |
| txn_req | output | 1 | Transaction request, held until completion |
| txn_class | output | 2 | Class of the requested slot |
| txn_slot | output | 5 | Index of the requested slot |
| txn_done | input | 1 | Transaction complete from the packet engine |
| busy | output | 1 | A pass is in progress |

## Verification
Directed descriptor layouts exercise the next-slot choice. Plain sequential chains separate the active/done filter from traversal. Forward and backward jump pointers show whether the forward-only rule holds. Skipped slots that carry a jump target and a last flag show whether either leaks through. A layout with no last flag confirms the end after slot 31. Passes with several class-enable combinations show class ordering. A slow completer, together with a strobe sent in mid-pass, shows that the walker waits for completion and ignores strobes while busy. The list of issued transactions and the read count are compared with hand-derived expectations.

// File: rtl/walker_pkg.sv
package walker_pkg;

    localparam int SLOT_W  = 5;
    localparam int SLOTS   = 1 << SLOT_W;
    localparam int CLS_W   = 2;
    localparam int NUM_CLS = 3;
    localparam int ADDR_W  = CLS_W + SLOT_W;

    typedef enum logic [CLS_W-1:0] {
        CLS_ISO   = 2'd0,
        CLS_INT   = 2'd1,
        CLS_ASYNC = 2'd2,
        CLS_NONE  = 2'd3
    } sched_cls_t;

    typedef struct packed {
        logic              last;
        logic              skip;
        logic              done;
        logic              active;
        logic [SLOT_W-1:0] jump;
    } slot_ctl_t;

    localparam int CTL_W = $bits(slot_ctl_t);

    typedef enum logic [2:0] {
        W_IDLE,
        W_READ,
        W_DECIDE,
        W_XFER,
        W_STEP
    } walk_st_t;

    function automatic logic slot_wants_issue(slot_ctl_t c);
        return !c.skip && c.active && !c.done;
    endfunction

endpackage

// File: rtl/walker_class_pick.sv
module walker_class_pick
    import walker_pkg::*;
#(
    parameter int N_CLS = walker_pkg::NUM_CLS
) (
    input  logic [N_CLS-1:0] en,
    input  sched_cls_t       cur,
    input  logic             from_start,
    output sched_cls_t       pick
);
    always_comb begin
        pick = CLS_NONE;
        for (int i = N_CLS - 1; i >= 0; i--) begin
            if (en[i] && (from_start || i > int'(cur))) begin
                pick = sched_cls_t'(CLS_W'(i));
            end
        end
    end
endmodule

// File: rtl/walker_slot_step.sv
module walker_slot_step
    import walker_pkg::*;
#(
    parameter int SW = walker_pkg::SLOT_W
) (
    input  slot_ctl_t      ctl,
    input  logic [SW-1:0]  cur_slot,
    output logic [SW-1:0]  nxt_slot,
    output logic           class_end,
    output logic           issue
);
    localparam logic [SW-1:0] TOP_SLOT = {SW{1'b1}};

    logic jump_ok;

    always_comb begin
        jump_ok   = !ctl.skip && (ctl.jump > cur_slot);
        nxt_slot  = jump_ok ? ctl.jump : cur_slot + 1'b1;
        class_end = (!ctl.skip && ctl.last) || (!jump_ok && cur_slot == TOP_SLOT);
        issue     = slot_wants_issue(ctl);
    end
endmodule

// File: rtl/sched_walker.sv
module sched_walker
    import walker_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_start,
    input  logic [NUM_CLS-1:0]    sched_en,
    output logic                  mem_rd_en,
    output logic [ADDR_W-1:0]     mem_rd_addr,
    input  logic [CTL_W-1:0]      mem_rd_data,
    output logic                  txn_req,
    output logic [CLS_W-1:0]      txn_class,
    output logic [SLOT_W-1:0]     txn_slot,
    input  logic                  txn_done,
    output logic                  busy
);
    walk_st_t          st_q;
    sched_cls_t        cls_q;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] nxt_q;
    logic              end_q;

    sched_cls_t        pick;
    slot_ctl_t         ctl;
    logic [SLOT_W-1:0] step_nxt;
    logic              step_end;
    logic              step_issue;

    assign ctl = slot_ctl_t'(mem_rd_data);

    walker_class_pick #(.N_CLS(NUM_CLS)) u_pick (
        .en         (sched_en),
        .cur        (cls_q),
        .from_start (st_q == W_IDLE),
        .pick       (pick)
    );

    walker_slot_step #(.SW(SLOT_W)) u_step (
        .ctl       (ctl),
        .cur_slot  (slot_q),
        .nxt_slot  (step_nxt),
        .class_end (step_end),
        .issue     (step_issue)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= W_IDLE;
            cls_q  <= CLS_ISO;
            slot_q <= '0;
            nxt_q  <= '0;
            end_q  <= 1'b0;
        end else begin
            unique case (st_q)
                W_IDLE: begin
                    if (frame_start && pick != CLS_NONE) begin
                        cls_q  <= pick;
                        slot_q <= '0;
                        st_q   <= W_READ;
                    end
                end
                W_READ: st_q <= W_DECIDE;
                W_DECIDE: begin
                    nxt_q <= step_nxt;
                    end_q <= step_end;
                    st_q  <= step_issue ? W_XFER : W_STEP;
                end
                W_XFER: begin
                    if (txn_done) st_q <= W_STEP;
                end
                W_STEP: begin
                    if (end_q) begin
                        if (pick == CLS_NONE) begin
                            st_q <= W_IDLE;
                        end else begin
                            cls_q  <= pick;
                            slot_q <= '0;
                            st_q   <= W_READ;
                        end
                    end else begin
                        slot_q <= nxt_q;
                        st_q   <= W_READ;
                    end
                end
                default: st_q <= W_IDLE;
            endcase
        end
    end

    assign busy        = (st_q != W_IDLE);
    assign mem_rd_en   = (st_q == W_READ);
    assign mem_rd_addr = {cls_q, slot_q};
    assign txn_req     = (st_q == W_XFER);
    assign txn_class   = cls_q;
    assign txn_slot    = slot_q;
endmodule

// File: rtl/sched_walker_chk.sv
module sched_walker_chk
    import walker_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              txn_req,
    input logic [CLS_W-1:0]  txn_class,
    input logic [SLOT_W-1:0] txn_slot,
    input logic              txn_done
);
    logic [ADDR_W-1:0] prev_addr_q;
    logic              have_prev_q;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            have_prev_q <= 1'b0;
            prev_addr_q <= '0;
        end else if (mem_rd_en) begin
            have_prev_q <= 1'b1;
            prev_addr_q <= mem_rd_addr;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd_en && !txn_req));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_req && !txn_done) |=> (txn_req && $stable(txn_class) && $stable(txn_slot)));

    // R9
    no_read_in_txn_chk: assert property (@(posedge clk) disable iff (rst)
        txn_req |-> !mem_rd_en);

    // R11
    single_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    // R11
    addr_forward_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && have_prev_q) |-> (mem_rd_addr > prev_addr_q));

    // R2
    class_code_chk: assert property (@(posedge clk) disable iff (rst)
        txn_req |-> (txn_class != 2'd3));
endmodule

bind sched_walker sched_walker_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .txn_req     (txn_req),
    .txn_class   (txn_class),
    .txn_slot    (txn_slot),
    .txn_done    (txn_done)
);

// File: tb/tb_sched_walker.sv
module tb_sched_walker;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_start = 1'b0;
    logic [2:0] sched_en = 3'b000;
    logic       mem_rd_en;
    logic [6:0] mem_rd_addr;
    logic [8:0] mem_rd_data = '0;
    logic       txn_req;
    logic [1:0] txn_class;
    logic [4:0] txn_slot;
    logic       txn_done = 1'b0;
    logic       busy;

    logic [8:0] mem [128];
    int issued[$];
    int exp_q[$];
    int reads = 0;
    int bad_rd = 0;
    int resp_delay = 0;
    int wait_cnt = 0;
    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sched_walker dut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .sched_en(sched_en),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .txn_req(txn_req), .txn_class(txn_class), .txn_slot(txn_slot),
        .txn_done(txn_done), .busy(busy)
    );

    // synchronous memory model and packet engine responder
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem[mem_rd_addr];
            reads <= reads + 1;
            if (txn_req) bad_rd <= bad_rd + 1;
        end
        if (rst) begin
            txn_done <= 1'b0;
            wait_cnt <= 0;
        end else begin
            txn_done <= 1'b0;
            if (txn_req && !txn_done) begin
                if (wait_cnt >= resp_delay) begin
                    txn_done <= 1'b1;
                    wait_cnt <= 0;
                    issued.push_back(int'(txn_class) * 32 + int'(txn_slot));
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end
        end
    end

    function automatic logic [8:0] mk(bit act, bit dn, bit sk, bit lst, int jmp);
        return {lst, sk, dn, act, 5'(jmp)};
    endfunction

    function automatic int E(int cls, int slot);
        return cls * 32 + slot;
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    task automatic check_eq(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_log(string req, int exp_reads);
        check_eq(req, "issued count", issued.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < issued.size(); i++)
            check_eq(req, $sformatf("issued[%0d]", i), issued[i], exp_q[i]);
        check_eq(req, "read count", reads, exp_reads);
        check_eq("R9", "reads during request", bad_rd, 0);
    endtask

    task automatic clear_all();
        for (int i = 0; i < 128; i++) mem[i] = '0;
        issued.delete();
        exp_q.delete();
        @(negedge clk);
        reads = 0;
        bad_rd = 0;
    endtask

    task automatic strobe();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    endtask

    task automatic run_pass(logic [2:0] en);
        sched_en = en;
        strobe();
        wait_idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        check_eq("R1", "busy after reset", int'(busy), 0);
        check_eq("R1", "mem_rd_en after reset", int'(mem_rd_en), 0);
        check_eq("R1", "txn_req after reset", int'(txn_req), 0);
    endtask

    task automatic t_sequential();
        clear_all();
        for (int s = 0; s < 4; s++) mem[s] = mk(1, 0, 0, s == 3, 0);
        run_pass(3'b001);
        exp_q = {E(0,0), E(0,1), E(0,2), E(0,3)};
        check_log("R7", 4);
    endtask

    task automatic t_filter();
        clear_all();
        mem[0] = mk(1, 1, 0, 0, 0);
        mem[1] = mk(0, 0, 0, 0, 0);
        mem[2] = mk(1, 0, 0, 0, 0);
        mem[3] = mk(1, 0, 0, 1, 0);
        run_pass(3'b001);
        exp_q = {E(0,2), E(0,3)};
        check_log("R3", 4);
    endtask

    task automatic t_jump();
        clear_all();
        mem[32+0] = mk(1, 0, 0, 0, 5);
        mem[32+5] = mk(1, 0, 0, 0, 2);
        mem[32+6] = mk(1, 0, 0, 1, 6);
        run_pass(3'b010);
        exp_q = {E(1,0), E(1,5), E(1,6)};
        check_log("R4 R5", 3);
    endtask

    task automatic t_skip();
        clear_all();
        mem[64+0]  = mk(1, 0, 1, 0, 10);
        mem[64+1]  = mk(1, 0, 1, 1, 0);
        mem[64+2]  = mk(1, 0, 0, 1, 0);
        mem[64+10] = mk(1, 0, 0, 0, 0);
        run_pass(3'b100);
        exp_q = {E(2,2)};
        check_log("R6", 3);
    endtask

    task automatic t_no_last();
        clear_all();
        mem[31] = mk(1, 0, 0, 0, 0);
        run_pass(3'b001);
        exp_q = {E(0,31)};
        check_log("R8", 32);
    endtask

    task automatic t_order();
        clear_all();
        mem[0]  = mk(1, 0, 0, 1, 0);
        mem[32] = mk(1, 0, 0, 1, 0);
        mem[64] = mk(1, 0, 0, 1, 0);
        run_pass(3'b111);
        exp_q = {E(0,0), E(1,0), E(2,0)};
        check_log("R2", 3);
        issued.delete();
        @(negedge clk);
        reads = 0;
        run_pass(3'b101);
        exp_q = {E(0,0), E(2,0)};
        check_log("R2", 2);
    endtask

    task automatic t_none_enabled();
        clear_all();
        mem[0] = mk(1, 0, 0, 1, 0);
        sched_en = 3'b000;
        strobe();
        check_eq("R2", "busy with no enable", int'(busy), 0);
        repeat (3) @(negedge clk);
        check_eq("R2", "reads with no enable", reads, 0);
    endtask

    task automatic t_slow_and_restrobe();
        clear_all();
        resp_delay = 3;
        for (int s = 0; s < 3; s++) mem[64+s] = mk(1, 0, 0, s == 2, 0);
        sched_en = 3'b100;
        strobe();
        repeat (4) @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        wait_idle();
        @(negedge clk);
        exp_q = {E(2,0), E(2,1), E(2,2)};
        check_log("R10", 3);
        check_eq("R9", "busy after slow pass", int'(busy), 0);
        resp_delay = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sequential();
        t_filter();
        t_jump();
        t_skip();
        t_no_last();
        t_order();
        t_none_enabled();
        t_slow_and_restrobe();
        report();
        $finish;
    end
endmodule